// File: doc/BRIEF.md
# Dual Store-Port Oldest-First Issue Arbiter

This block arbitrates issue for a queue of instruction entries that share two store ports. It keeps one valid bit per entry and takes, each cycle, per-entry operand-ready and store-class flags, an age stamp and a tag as flat port vectors. An entry requests when it is valid, its operands are ready and it is store-class. Entries at even queue positions compete only for store port 0, and entries at odd positions compete only for store port 1. On each port the oldest requester wins, found by a combinational selection tree over that port's half of the queue.

A granted entry leaves the queue at the next clock edge. In that same edge the block raises a one-cycle wake pulse carrying the granted entry's tag, so that the twin entry in a companion queue can begin to request. A flush empties the queue in one cycle and blocks any grant while it is high.

Top module: `dual_store_issue_arb`

## Requirements
- R1: After reset every entry is invalid, and no grant or wake is asserted.
- R2: A 1 in bit i of `alloc_i` makes entry i valid from the next clock edge, and `entry_vld_o` shows it.
- R3: An entry is granted only if it is valid, its `ready_i` bit is 1 and its `store_i` bit is 1. With no such entry on a port, that port's grant is low.
- R4: Port 0 grants only even queue indices (`gnt_idx0_o` bit 0 is 0). Port 1 grants only odd queue indices (`gnt_idx1_o` bit 0 is 1).
- R5: Each port grants its oldest requester. An age stamp is {epoch bit at the MSB, count below it}. Between two stamps with the same epoch, the smaller count is older. Between two stamps with different epochs and distinct counts, the larger count is older.
- R6: Among requesters on one port whose stamps are equal, the lowest queue index wins.
- R7: Each port grants at most one entry per cycle. The granted entry is invalid from the next edge, and the next oldest requester is granted then.
- R8: One cycle after port p grants, `wake_vld_o[p]` is high for one cycle, with the granted entry's tag (its `tag_i` slice in the grant cycle) on that port's wake tag output.
- R9: While `flush` is high, both grants are low. At the next edge every entry becomes invalid, and any `alloc_i` bits in that cycle are ignored.
- R10: If an entry is granted in the same cycle that its `alloc_i` bit is set, it stays valid after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Clears all entries, blocks grants |
| alloc_i | input | DEPTH | Per-entry allocate strobes |
| ready_i | input | DEPTH | Per-entry operands-available flags |
| store_i | input | DEPTH | Per-entry store-class flags |
| age_i | input | DEPTH*AGE_W | Age stamps, entry i at [i*AGE_W +: AGE_W] |
| tag_i | input | DEPTH*TAG_W | Companion tags, entry i at [i*TAG_W +: TAG_W] |
| entry_vld_o | output | DEPTH | Current valid bits |
| gnt_vld_o | output | 2 | Grant on store port 0 / 1 |
| gnt_idx0_o | output | IDX_W | Queue index granted on port 0 |
| gnt_idx1_o | output | IDX_W | Queue index granted on port 1 |
| wake_vld_o | output | 2 | Wake pulse for port 0 / 1 |
| wake_tag0_o | output | TAG_W | Tag carried by the port 0 wake |
| wake_tag1_o | output | TAG_W | Tag carried by the port 1 wake |

## Verification
Two events can fall in the same cycle. A flush can arrive while ready store entries would otherwise win a port, and an allocate can target the very entry that is being granted. The bench drives flush together with a full queue of ready entries and an allocate of every entry. It then checks that both grants stay low, that the queue is empty after the edge and that no wake follows. For the second case it holds entry 0's allocate strobe high during its grant cycle and checks that the entry is still valid while its wake pulse appears.

// File: rtl/dual_store_issue_arb.sv
module dual_store_issue_arb #(
  parameter int DEPTH = 16,
  parameter int AGE_W = 5,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [DEPTH-1:0]         alloc_i,
  input  logic [DEPTH-1:0]         ready_i,
  input  logic [DEPTH-1:0]         store_i,
  input  logic [DEPTH*AGE_W-1:0]   age_i,
  input  logic [DEPTH*TAG_W-1:0]   tag_i,
  output logic [DEPTH-1:0]         entry_vld_o,
  output logic [1:0]               gnt_vld_o,
  output logic [IDX_W-1:0]         gnt_idx0_o,
  output logic [IDX_W-1:0]         gnt_idx1_o,
  output logic [1:0]               wake_vld_o,
  output logic [TAG_W-1:0]         wake_tag0_o,
  output logic [TAG_W-1:0]         wake_tag1_o
);

  localparam int HALF   = DEPTH / 2;
  localparam int NODES  = 2 * HALF - 1;
  localparam int LIDX_W = $clog2(HALF);
  localparam int CNT_W  = AGE_W - 1;

  logic [DEPTH-1:0] vld_q, req, clr;
  logic [1:0][HALF-1:0] req_h;
  logic [1:0][HALF*AGE_W-1:0] age_h;
  logic [LIDX_W:0] win0, win1;
  logic [TAG_W-1:0] sel_tag0, sel_tag1;

  // a strictly older than b; epoch mismatch means the count has wrapped
  function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    return (a[CNT_W-1:0] < b[CNT_W-1:0]) ^ (a[CNT_W] != b[CNT_W]);
  endfunction

  // heap-ordered tree: leaves HALF-1.., left child holds lower indices
  function automatic logic [LIDX_W:0] pick(input logic [HALF-1:0] rq,
                                           input logic [HALF*AGE_W-1:0] ag);
    logic                nv [NODES];
    logic [LIDX_W-1:0]   ni [NODES];
    logic [AGE_W-1:0]    na [NODES];
    logic                sel;
    for (int j = 0; j < HALF; j++) begin
      nv[HALF-1+j] = rq[j];
      ni[HALF-1+j] = LIDX_W'(j);
      na[HALF-1+j] = ag[j*AGE_W +: AGE_W];
    end
    for (int k = HALF - 2; k >= 0; k--) begin
      sel   = nv[2*k+2] && (!nv[2*k+1] || older(na[2*k+2], na[2*k+1]));
      nv[k] = nv[2*k+1] || nv[2*k+2];
      ni[k] = sel ? ni[2*k+2] : ni[2*k+1];
      na[k] = sel ? na[2*k+2] : na[2*k+1];
    end
    return {nv[0], ni[0]};
  endfunction

  assign req = vld_q & ready_i & store_i;

  for (genvar p = 0; p < 2; p++) begin : g_port
    for (genvar j = 0; j < HALF; j++) begin : g_leaf
      assign req_h[p][j] = req[2*j+p];
      assign age_h[p][j*AGE_W +: AGE_W] = age_i[(2*j+p)*AGE_W +: AGE_W];
    end
  end

  assign win0 = pick(req_h[0], age_h[0]);
  assign win1 = pick(req_h[1], age_h[1]);

  assign gnt_vld_o  = {win1[LIDX_W], win0[LIDX_W]} & {2{~flush}};
  assign gnt_idx0_o = {win0[LIDX_W-1:0], 1'b0};
  assign gnt_idx1_o = {win1[LIDX_W-1:0], 1'b1};

  always_comb begin
    clr = '0;
    if (gnt_vld_o[0]) clr[gnt_idx0_o] = 1'b1;
    if (gnt_vld_o[1]) clr[gnt_idx1_o] = 1'b1;
  end

  assign sel_tag0 = tag_i[gnt_idx0_o*TAG_W +: TAG_W];
  assign sel_tag1 = tag_i[gnt_idx1_o*TAG_W +: TAG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q       <= '0;
      wake_vld_o  <= '0;
      wake_tag0_o <= '0;
      wake_tag1_o <= '0;
    end else begin
      vld_q       <= flush ? '0 : ((vld_q & ~clr) | alloc_i);
      wake_vld_o  <= gnt_vld_o;
      wake_tag0_o <= sel_tag0;
      wake_tag1_o <= sel_tag1;
    end
  end

  assign entry_vld_o = vld_q;

  p_grant_req0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o[0] |-> (vld_q[gnt_idx0_o] && ready_i[gnt_idx0_o] && store_i[gnt_idx0_o]));
  p_grant_req1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o[1] |-> (vld_q[gnt_idx1_o] && ready_i[gnt_idx1_o] && store_i[gnt_idx1_o]));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld_o[0] && !alloc_i[gnt_idx0_o]) |=> !vld_q[$past(gnt_idx0_o)]);
  p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o[0] |=> (wake_vld_o[0] && wake_tag0_o == $past(sel_tag0)));
  p_flush_nogrant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> gnt_vld_o == 2'b00);
  p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> vld_q == '0);
  p_realloc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld_o[1] && alloc_i[gnt_idx1_o] && !flush) |=> vld_q[$past(gnt_idx1_o)]);

endmodule

// File: tb/dual_store_issue_arb_bench.sv
`timescale 1ns/100ps
module dual_store_issue_arb_bench;
  localparam int DEPTH = 16, AGE_W = 5, TAG_W = 6, IDX_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [DEPTH-1:0] alloc = '0, rdy = '0, st = '0;
  logic [DEPTH*AGE_W-1:0] age_flat;
  logic [DEPTH*TAG_W-1:0] tag_flat;
  logic [AGE_W-1:0] age_a [DEPTH];
  logic [DEPTH-1:0] entry_vld;
  logic [1:0] gnt_vld, wake_vld;
  logic [IDX_W-1:0] gi0, gi1;
  logic [TAG_W-1:0] wt0, wt1;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < DEPTH; i++) begin
      age_flat[i*AGE_W +: AGE_W] = age_a[i];
      tag_flat[i*TAG_W +: TAG_W] = TAG_W'(40 + i);
    end

  dual_store_issue_arb u_dual_store_issue_arb (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_i(alloc), .ready_i(rdy),
    .store_i(st), .age_i(age_flat), .tag_i(tag_flat), .entry_vld_o(entry_vld),
    .gnt_vld_o(gnt_vld), .gnt_idx0_o(gi0), .gnt_idx1_o(gi1),
    .wake_vld_o(wake_vld), .wake_tag0_o(wt0), .wake_tag1_o(wt1));

  typedef struct packed {
    logic [15:0] al, rd, sf;
    logic [1:0]  gv;
    logic [3:0]  i0, i1;
  } vec_t;

  // ages: entry i count = (i*7)%16, epoch 0
  localparam vec_t VT [9] = '{
    '{16'hFFFF, 16'hFFFF, 16'hFFFF, 2'b11, 4'd0,  4'd7},
    '{16'hFFFF, 16'hFFFF, 16'hFFFE, 2'b11, 4'd14, 4'd7},
    '{16'hFFFF, 16'hFF7F, 16'hFFFF, 2'b11, 4'd0,  4'd5},
    '{16'h00F0, 16'hFFFF, 16'hFFFF, 2'b11, 4'd6,  4'd7},
    '{16'hFFFF, 16'hFFFF, 16'h0000, 2'b00, 4'd0,  4'd0},
    '{16'h5555, 16'hFFFF, 16'hFFFF, 2'b01, 4'd0,  4'd0},
    '{16'hFFFF, 16'hAAAA, 16'hFFFF, 2'b10, 4'd0,  4'd7},
    '{16'h0300, 16'hFFFF, 16'hFFFF, 2'b11, 4'd8,  4'd9},
    '{16'h8000, 16'hFFFF, 16'hFFFF, 2'b10, 4'd0,  4'd15}
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic default_ages();
    for (int i = 0; i < DEPTH; i++) age_a[i] = {1'b0, 4'((i * 7) % 16)};
  endtask

  task automatic flush_cycle();
    @(negedge clk);
    flush = 1'b1; alloc = '0; rdy = '0; st = '0;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic two_even(input logic [AGE_W-1:0] a0, input logic [AGE_W-1:0] a2,
                          input int exp_idx, input string rq);
    flush_cycle();
    age_a[0] = a0; age_a[2] = a2;
    alloc = 16'h0005;
    @(negedge clk);
    alloc = '0; rdy = '1; st = '1;
    #1;
    chk(gnt_vld[0] && gi0 == IDX_W'(exp_idx), rq, "oldest even", {gnt_vld, gi0}, {2'b01, 4'(exp_idx)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    default_ages();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(entry_vld == '0 && gnt_vld == '0 && wake_vld == '0, "R1", "reset state",
        {entry_vld, gnt_vld, wake_vld}, 0);

    // R2 allocate
    @(negedge clk);
    alloc = 16'h0033;
    @(negedge clk);
    alloc = '0;
    #1;
    chk(entry_vld == 16'h0033, "R2", "valid after alloc", entry_vld, 16'h0033);

    // R3 ready store entries that are not valid
    flush_cycle();
    rdy = '1; st = '1;
    #1;
    chk(gnt_vld == 2'b00, "R3", "no grant when empty", gnt_vld, 0);

    // table: R3 R4 R5
    for (int v = 0; v < 9; v++) begin
      flush_cycle();
      alloc = VT[v].al;
      @(negedge clk);
      alloc = '0; rdy = VT[v].rd; st = VT[v].sf;
      #1;
      chk({gnt_vld, gnt_vld[0] ? gi0 : 4'd0, gnt_vld[1] ? gi1 : 4'd0} ==
          {VT[v].gv, VT[v].gv[0] ? VT[v].i0 : 4'd0, VT[v].gv[1] ? VT[v].i1 : 4'd0},
          "R3 R4 R5", $sformatf("table vector %0d", v),
          {gnt_vld, gi0, gi1}, {VT[v].gv, VT[v].i0, VT[v].i1});
    end

    // R5 epoch wrap: larger count older across epochs; R7 and R8 follow on
    two_even({1'b1, 4'd1}, {1'b0, 4'd14}, 2, "R5");
    @(negedge clk);
    #1;
    chk(entry_vld == 16'h0001, "R7", "granted entry cleared", entry_vld, 16'h0001);
    chk(gnt_vld[0] && gi0 == 4'd0, "R7", "next oldest granted", {gnt_vld, gi0}, {2'b01, 4'd0});
    chk(wake_vld == 2'b01 && wt0 == 6'd42, "R8", "wake pulse tag", {wake_vld, wt0}, {2'b01, 6'd42});
    rdy = '0;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk(wake_vld == 2'b00, "R8", "wake lasts one cycle", wake_vld, 0);

    two_even({1'b0, 4'd9}, {1'b0, 4'd3}, 2, "R5");
    two_even({1'b0, 4'd5}, {1'b0, 4'd5}, 0, "R6");
    default_ages();

    // R9 flush with full ready queue and allocate
    flush_cycle();
    alloc = '1;
    @(negedge clk);
    flush = 1'b1; alloc = '1; rdy = '1; st = '1;
    #1;
    chk(gnt_vld == 2'b00, "R9", "no grant during flush", gnt_vld, 0);
    @(negedge clk);
    flush = 1'b0; alloc = '0; rdy = '0;
    #1;
    chk(entry_vld == '0 && wake_vld == '0, "R9", "queue empty after flush",
        {entry_vld, wake_vld}, 0);

    // R10 allocate during grant of same entry
    alloc = 16'h0001;
    @(negedge clk);
    rdy = '1; st = '1;
    #1;
    chk(gnt_vld == 2'b01 && gi0 == 4'd0, "R10", "entry 0 granted", {gnt_vld, gi0}, {2'b01, 4'd0});
    @(negedge clk);
    alloc = '0; rdy = '0;
    #1;
    chk(entry_vld[0] && wake_vld[0], "R10", "re-allocated entry valid", {entry_vld, wake_vld}, {16'h0001, 2'b01});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule